// File: doc/BRIEF.md
# Endpoint Descriptor List Pointer Tracker

This block holds two pointers for one linked list of endpoint descriptors in a USB host controller. The first is the list's head address, which software programs. The second is the address of the descriptor now being worked on. The descriptor-fetch logic drives the current pointer forward, one descriptor at a time.

Reaching the end of the list does not restart the walk by itself. The block restarts from the head only when software has raised a list-filled flag. That flag is cleared when the reload happens. Because of this, the current pointer keeps its value from one frame to the next.

Software reaches the pointers through a small register port. Writes to the current pointer are ignored while the list is enabled. Every pointer is stored without its low alignment bits, and those bits always read back as zero.

Top module: `ed_list_tracker`

## Requirements
- R1: After reset, the head pointer, the current pointer and the filled flag all read zero, and `reload_done` is low. A zero current pointer means the end of the list.
- R2: On `advance_req` with a nonzero aligned `next_addr`, the current pointer takes that address on the next clock edge. Bits 3:0 are dropped.
- R3: Without hardware events or accepted writes, the current pointer holds its value over any number of cycles. Nothing resets it at frame boundaries.
- R4: At the end of the list with the filled flag set, the current pointer is loaded from the head pointer and the flag is cleared. `reload_done` is high for exactly the one cycle after that edge.
- R5: At the end of the list with the filled flag clear, the current pointer is unchanged and `reload_done` stays low.
- R6: Two conditions each count as the end of the list: `end_of_list` high, or `advance_req` with a `next_addr` whose bits 31:4 are zero.
- R7: A write to the current pointer (`reg_addr` = 1) takes effect only while `list_enable` is low. While it is high, the write has no effect.
- R8: If `advance_req` or `end_of_list` occurs in the same cycle as a write to the current pointer, the hardware update is applied and the write is dropped.
- R9: The filled flag is bit 0 at `reg_addr` = 2. Writing 1 sets it. Writing 0 has no effect. A set in the same cycle as a reload leaves the flag set.
- R10: The register map is: address 0 is the head pointer, address 1 is the current pointer, address 2 is the flag, and address 3 reads zero. Pointer reads always return bits 3:0 as zero.
- R11: The head pointer (`reg_addr` = 0) can be written whether or not the list is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| list_enable | input | 1 | List enable; while high, the current pointer is read-only to software |
| advance_req | input | 1 | The present descriptor has been served |
| next_addr | input | 32 | Next-descriptor address from the fetch logic |
| end_of_list | input | 1 | End of the list reached |
| reg_addr | input | 2 | Register select: 0 head, 1 current, 2 flag |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| reload_done | output | 1 | One-cycle pulse after a reload from the head |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and 4 alignment bits. With these values, the address patterns it drives use the top address bits and nonzero low bits, so the tests show that the low bits are masked. They also cover the zero-next-address case, which is detected only on the stored bits 31:4. The directed scenarios that follow drive conflicting events in the same cycle: a write against an advance, and a flag set against a reload.

// File: rtl/ed_list_tracker.sv
module ed_list_tracker #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              list_enable,
  input  logic              advance_req,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              end_of_list,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_wdata,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              reload_done
);
  localparam int PW = ADDR_W - ALIGN_BITS;

  logic [PW-1:0] head_q, cur_q;
  logic          fill_q, reload_q;

  wire [PW-1:0] next_ptr = next_addr[ADDR_W-1:ALIGN_BITS];
  wire [PW-1:0] wr_ptr   = reg_wdata[ADDR_W-1:ALIGN_BITS];
  wire hw_evt   = advance_req | end_of_list;
  wire eol      = end_of_list | (advance_req & (next_ptr == '0));
  wire adv      = advance_req & ~eol;
  wire reload   = eol & fill_q;
  wire wr_head  = reg_wr & (reg_addr == 2'd0);
  wire wr_cur   = reg_wr & (reg_addr == 2'd1) & ~list_enable & ~hw_evt;
  wire set_fill = reg_wr & (reg_addr == 2'd2) & reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q   <= '0;
      cur_q    <= '0;
      fill_q   <= 1'b0;
      reload_q <= 1'b0;
    end else begin
      if (wr_head) head_q <= wr_ptr;
      if (reload)      cur_q <= head_q;
      else if (adv)    cur_q <= next_ptr;
      else if (wr_cur) cur_q <= wr_ptr;
      fill_q   <= set_fill | (fill_q & ~reload);
      reload_q <= reload;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {head_q, {ALIGN_BITS{1'b0}}};
      2'd1:    reg_rdata = {cur_q, {ALIGN_BITS{1'b0}}};
      2'd2:    reg_rdata = {{(ADDR_W-1){1'b0}}, fill_q};
      default: reg_rdata = '0;
    endcase
  end

  assign reload_done = reload_q;
endmodule

// File: rtl/ed_list_tracker_chk.sv
module ed_list_tracker_chk #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       list_enable,
  input logic                       advance_req,
  input logic [ADDR_W-1:0]          next_addr,
  input logic                       end_of_list,
  input logic [1:0]                 reg_addr,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_wdata,
  input logic [ADDR_W-1:0]          reg_rdata,
  input logic                       reload_done,
  input logic [ADDR_W-ALIGN_BITS-1:0] head_q,
  input logic [ADDR_W-ALIGN_BITS-1:0] cur_q,
  input logic                       fill_q
);
  wire zero_next = advance_req && (next_addr[ADDR_W-1:ALIGN_BITS] == '0);
  wire at_end    = end_of_list || zero_next;
  wire flag_set  = reg_wr && reg_addr == 2'd2 && reg_wdata[0];

  AST_RELOAD_FROM_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    at_end && fill_q |=> reload_done && cur_q == $past(head_q)); // R4
  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    at_end && fill_q && !flag_set |=> !fill_q); // R4
  AST_HOLD_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    at_end && !fill_q |=> $stable(cur_q) && !reload_done); // R5
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    advance_req && !at_end |=> cur_q == $past(next_addr[ADDR_W-1:ALIGN_BITS])); // R2
  AST_RO_WHEN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    list_enable && !advance_req && !end_of_list |=> $stable(cur_q)); // R7
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr != 2'd2 |-> reg_rdata[ALIGN_BITS-1:0] == '0); // R10
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> fill_q); // R9
endmodule

bind ed_list_tracker ed_list_tracker_chk #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .list_enable(list_enable), .advance_req(advance_req),
  .next_addr(next_addr), .end_of_list(end_of_list), .reg_addr(reg_addr),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reload_done(reload_done), .head_q(head_q), .cur_q(cur_q), .fill_q(fill_q));

// File: tb/sim_ed_list_tracker.sv
module sim_ed_list_tracker;
  logic clk = 0, rst_n = 0, list_enable = 0, advance_req = 0, end_of_list = 0, reg_wr = 0;
  logic [31:0] next_addr = 0, reg_wdata = 0, reg_rdata;
  logic [1:0]  reg_addr = 0;
  logic        reload_done;
  int checks = 0, fails = 0;
  bit done = 0;

  ed_list_tracker u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, string req, logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic adv(logic [31:0] n);
    advance_req = 1; next_addr = n;
    @(negedge clk);
    advance_req = 0; next_addr = 0;
  endtask

  task automatic t_reset;
    rd(0, "R1 head", 0); rd(1, "R1 current", 0); rd(2, "R1 flag", 0);
    chk("R1 reload_done", {31'd0, reload_done}, 0);
  endtask

  task automatic t_head_align;
    list_enable = 1;
    wr(0, 32'h1234_567F);
    rd(0, "R11 R10 head write while enabled, low bits zero", 32'h1234_5670);
    rd(3, "R10 unused address", 0);
  endtask

  task automatic t_advance;
    adv(32'h0000_1008); rd(1, "R2 advance", 32'h0000_1000);
    adv(32'hABCD_001F); rd(1, "R2 advance high bits", 32'hABCD_0010);
  endtask

  task automatic t_persist;
    repeat (6) @(negedge clk);
    rd(1, "R3 persists", 32'hABCD_0010);
  endtask

  task automatic t_end_empty;
    adv(32'h0000_000C);
    chk("R5 no pulse", {31'd0, reload_done}, 0);
    rd(1, "R5 R6 zero next, flag clear", 32'hABCD_0010);
    end_of_list = 1; @(negedge clk); end_of_list = 0;
    chk("R5 no pulse eol", {31'd0, reload_done}, 0);
    rd(1, "R5 eol flag clear", 32'hABCD_0010);
  endtask

  task automatic t_flag;
    wr(2, 0); rd(2, "R9 write zero ignored", 0);
    wr(2, 1); rd(2, "R9 write one sets", 1);
    wr(2, 0); rd(2, "R9 zero does not clear", 1);
  endtask

  task automatic t_reload;
    end_of_list = 1; @(negedge clk); end_of_list = 0;
    chk("R4 pulse", {31'd0, reload_done}, 1);
    rd(1, "R4 current from head", 32'h1234_5670);
    rd(2, "R4 flag cleared", 0);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'd0, reload_done}, 0);
    adv(32'h0000_2000);
    wr(2, 1);
    adv(32'h0000_0000);
    chk("R6 pulse zero next", {31'd0, reload_done}, 1);
    rd(1, "R6 zero next reloads", 32'h1234_5670);
  endtask

  task automatic t_write_gate;
    wr(1, 32'h0000_5550); rd(1, "R7 write ignored when enabled", 32'h1234_5670);
    list_enable = 0;
    wr(1, 32'h0000_5559); rd(1, "R7 write when disabled", 32'h0000_5550);
  endtask

  task automatic t_priority;
    reg_addr = 1; reg_wdata = 32'h0000_7770; reg_wr = 1;
    advance_req = 1; next_addr = 32'h0000_8880;
    @(negedge clk);
    reg_wr = 0; advance_req = 0;
    rd(1, "R8 hardware wins", 32'h0000_8880);
  endtask

  task automatic t_set_vs_reload;
    wr(2, 1);
    reg_addr = 2; reg_wdata = 1; reg_wr = 1; end_of_list = 1;
    @(negedge clk);
    reg_wr = 0; end_of_list = 0;
    chk("R9 reload with set", {31'd0, reload_done}, 1);
    rd(2, "R9 set wins over clear", 1);
    rd(1, "R4 reload value", 32'h1234_5670);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_head_align; t_advance; t_persist; t_end_empty;
    t_flag; t_reload; t_write_gate; t_priority; t_set_vs_reload;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule